// File: doc/BRIEF.md
# Sliding Window Ones Counter

This block watches a one-bit serial stream and reports how many ones occur in a moving window of 128 bit positions. The window holds the bit on the input in the present cycle and the 127 bits accepted before it. A bit is accepted on a rising clock edge while the enable is high.

The output is Mealy-style. The stored state is a ready-made count of the 127 most recent accepted bits. The output stage only adds the live input bit to that count. As a result, the path from the input to the output is a single incrementer, and the path from the clock to the output is a single register plus that same incrementer.

An asynchronous active-low reset empties the history and the count. Until 127 bits have been accepted, the window positions that have not yet been filled count as zeros.

Top module: `swc_window_counter`

## Requirements
- R1: `ones_count` equals the number of ones among the 127 most recently accepted bits plus the present value of `din`.
- R2: A change of `din` changes `ones_count` within the same cycle, with no clock edge in between. A one on `din` adds exactly one to the count.
- R3: While reset is asserted, and after its release until bits have been accepted, the window positions not yet filled count as zero. Directly after reset, `ones_count` equals `din`.
- R4: Asserting `rst_n` low clears the stored history and the stored count at once, without waiting for a clock edge. It does so even in the middle of a stream.
- R5: While `shift_en` is low, rising edges accept nothing. Bits presented during that time are never counted later. `ones_count` still follows the live `din`.
- R6: After 128 or more consecutive accepted ones, with `din` held at one, `ones_count` reads 128, its maximum value.
- R7: A bit stops counting once 127 newer bits have been accepted after it. Example: after 128 accepted ones followed by an accepted zero and a live zero on `din`, the count reads 126.
- R8: `ones_count` never exceeds 128 and is an unsigned binary value 8 bits wide.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to clk |
| shift_en | input | 1 | High: the current `din` is accepted at the next rising edge |
| din | input | 1 | Serial data bit |
| ones_count | output | 8 | Ones in the live bit plus the previous 127 accepted bits |

## Verification
The stored count can gain the entering bit and lose the departing bit on the same edge. When both are ones, the count must stay unchanged. Random streams and long runs of ones make this case happen often, and a bench model that keeps its own 127-bit history judges each cycle. The live-bit addition and the held state also meet when the enable is low: `din` keeps toggling while the count must not move. This is checked against the model's frozen history on every such cycle.

// File: rtl/swc_pkg.sv
package swc_pkg;
  // Width needed to hold counts 0..win inclusive.
  function automatic int cnt_width(input int win);
    return $clog2(win + 1);
  endfunction
endpackage

// File: rtl/swc_history.sv
// Shift history of past accepted bits; exposes the bit about to leave.
module swc_history #(
  parameter int DEPTH = 127
) (
  input  logic clk,
  input  logic rst_n,
  input  logic shift_en,
  input  logic din,
  output logic oldest
);
  logic [DEPTH-1:0] hist_q;
  logic [DEPTH-1:0] hist_d;

  // stage 0 takes the live bit, every other stage takes its neighbour
  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    if (g == 0) begin : g_head
      always_comb hist_d[g] = shift_en ? din : hist_q[g];
    end else begin : g_body
      always_comb hist_d[g] = shift_en ? hist_q[g-1] : hist_q[g];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hist_q[g] <= 1'b0;
      else        hist_q[g] <= hist_d[g];
    end
  end

  assign oldest = hist_q[DEPTH-1];

  assert_accept_bit_R1: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> hist_q[0] == $past(din));
  assert_history_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(hist_q));
endmodule

// File: rtl/swc_tally.sv
// Registered count of ones held in the history.
module swc_tally #(
  parameter int DEPTH = 127,
  parameter int CW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          shift_en,
  input  logic          din,
  input  logic          oldest,
  output logic [CW-1:0] part_q
);
  logic [CW-1:0] part_d;
  logic [CW-1:0] add_v;
  logic [CW-1:0] sub_v;

  always_comb begin
    add_v  = {{(CW-1){1'b0}}, din};
    sub_v  = {{(CW-1){1'b0}}, oldest};
    part_d = part_q;
    if (shift_en) part_d = part_q + add_v - sub_v;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) part_q <= '0;
    else        part_q <= part_d;
  end

  assert_partial_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    part_q <= CW'(DEPTH));
  assert_tally_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(part_q));
  assert_tally_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !din && oldest) |=> part_q == $past(part_q) - 1'b1);
  assert_tally_gain_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && din && !oldest) |=> part_q == $past(part_q) + 1'b1);
endmodule

// File: rtl/swc_window_counter.sv
module swc_window_counter #(
  parameter int WIN = 128,
  localparam int HIST = WIN - 1,
  localparam int CW   = swc_pkg::cnt_width(WIN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          shift_en,
  input  logic          din,
  output logic [CW-1:0] ones_count
);
  logic          oldest;
  logic [CW-1:0] part_q;

  swc_history #(.DEPTH(HIST)) u_hist (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .din(din), .oldest(oldest)
  );

  swc_tally #(.DEPTH(HIST), .CW(CW)) u_tally (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .din(din),
    .oldest(oldest), .part_q(part_q)
  );

  // Mealy output: stored partial count plus the live bit
  always_comb ones_count = part_q + {{(CW-1){1'b0}}, din};

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ones_count <= CW'(WIN));
  assert_live_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    din |-> ones_count != '0);
endmodule

// File: tb/tb_swc_window_counter.sv
module tb_swc_window_counter;
  localparam int CLK_PERIOD = 10;
  localparam int WIN = 128;

  logic       clk;
  logic       rst_n;
  logic       shift_en;
  logic       din;
  logic [7:0] ones_count;

  logic [WIN-2:0] hist_m;
  int checks;
  int fails;

  swc_window_counter dut (
    .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .din(din),
    .ones_count(ones_count)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int model_count(input logic [WIN-2:0] h, input logic d);
    return $countones(h) + int'(d);
  endfunction

  task automatic check(input string tag, input int expv);
    checks++;
    if (int'(ones_count) != expv) begin
      fails++;
      $display("FAIL %s: ones_count=%0d expected=%0d at %0t", tag, ones_count, expv, $time);
    end
  endtask

  // drive one cycle: set inputs after negedge, check, then let the edge accept
  task automatic cycle(input logic en, input logic d, input string tag);
    @(negedge clk);
    shift_en = en;
    din      = d;
    #1;
    check(tag, model_count(hist_m, d));
    @(posedge clk);
    if (en) hist_m = {hist_m[WIN-3:0], d};
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    hist_m = '0;
    din = 1'b1;
    #1;
    check("R4 reset clears, live one", 1);
    din = 1'b0;
    #1;
    check("R4 reset clears, live zero", 0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R3 empty window after reset", 0);
  endtask

  initial begin
    checks = 0;
    fails  = 0;
    rst_n = 1'b0;
    shift_en = 1'b0;
    din = 1'b0;
    hist_m = '0;
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    do_reset();

    // R3: partial fill counts missing positions as zeros
    for (int i = 0; i < 5; i++) cycle(1'b1, 1'b1, "R3 partial fill");

    // R2: live bit moves the count in the same cycle
    @(negedge clk);
    shift_en = 1'b0;
    din = 1'b0;
    #1;
    begin
      int a;
      a = int'(ones_count);
      din = 1'b1;
      #1;
      check("R2 same-cycle rise", a + 1);
      din = 1'b0;
      #1;
      check("R2 same-cycle fall", a);
    end

    // R6: long run of ones reaches 128
    for (int i = 0; i < 140; i++) cycle(1'b1, 1'b1, "R6 run of ones");
    cycle(1'b0, 1'b1, "R6 maximum 128");
    // R7: departing bit leaves the count
    cycle(1'b1, 1'b0, "R7 oldest departs");
    cycle(1'b0, 1'b0, "R7 count 126");
    for (int i = 0; i < 200; i++) cycle(1'b1, 1'b0, "R7 run of zeros");

    // R5: enable low, toggling input must not be remembered
    for (int i = 0; i < 40; i++) cycle(1'b1, 1'($urandom_range(0, 1)), "R1 load");
    for (int i = 0; i < 60; i++) cycle(1'b0, 1'(i % 2), "R5 hold with toggling din");
    for (int i = 0; i < 130; i++) cycle(1'b1, 1'b0, "R5 ignored bits never counted");

    // R1/R8: random streams with random enable and random runs
    for (int blk = 0; blk < 40; blk++) begin
      int mode;
      mode = int'($urandom_range(0, 3));
      for (int i = 0; i < 60; i++) begin
        logic d;
        logic e;
        e = ($urandom_range(0, 3) != 0);
        if (mode == 0)      d = 1'b1;
        else if (mode == 1) d = 1'b0;
        else                d = 1'($urandom_range(0, 1));
        cycle(e, d, "R1 random window");
      end
    end

    // R4: reset mid-stream, then refill
    for (int i = 0; i < 50; i++) cycle(1'b1, 1'b1, "R1 before mid reset");
    do_reset();
    for (int i = 0; i < 300; i++) cycle(1'b1, 1'($urandom_range(0, 1)), "R4 refill after reset");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule